// File: doc/BRIEF.md
# OUT Endpoint Receive FIFO with Word Read Port

This block buffers the payload of one bulk OUT endpoint. The packet receiver pushes bytes one per cycle through a byte-wide write port and marks the last byte of each packet with a tail flag. Firmware drains the buffer through a 32-bit data view. Each read pops up to four bytes, packed little-endian. A lane code tells how many bytes of the word are valid. A word never spans a packet tail, so the final bytes of a packet can come back as a partial word.

Two status flags drive the service routine. The pending flag says that unread bytes are present. The end-of-data flag is raised with it when the current service chunk is the last one, meaning either that fewer than `CHUNK` (64) bytes remain or that a packet tail lies within the first `CHUNK` bytes. The byte count is visible at all times. A count above `CHUNK` is flagged as corruption. A control-register write with bit 4 set flushes the buffer. A byte offered while the buffer is full is dropped, and a sticky overflow flag records the loss.

Top module: `usb_out_fifo_rd`

## Requirements
- R1: After reset, byte_count is 0 and pending, end_of_data, count_err and overflow are 0. rd_data is 0 and rd_lanes is 0.
- R2: Each accepted write adds one to byte_count, and each read subtracts the number of bytes it delivers. A write and a read in the same cycle are both applied. byte_count never exceeds DEPTH.
- R3: rd_data packs bytes little-endian: the oldest unread byte is in bits 7:0 and the next in bits 15:8, and so on. Bytes are delivered in arrival order.
- R4: rd_lanes is 0x1, 0x3, 0x7 or 0xF for 1, 2, 3 or 4 valid bytes. The valid count is the smallest of: 4, byte_count, and the number of bytes up to and including the first tail-marked byte. Invalid lanes of rd_data read 0.
- R5: A read with byte_count 0 returns rd_data 0 and rd_lanes 0, and leaves byte_count unchanged.
- R6: pending is 1 exactly when byte_count is nonzero.
- R7: end_of_data is 1 when pending is 1 and either byte_count < 64 or a tail-marked byte lies within the first 64 unread bytes. Otherwise end_of_data is 0. It is 0 whenever the count is 0.
- R8: count_err is 1 exactly when byte_count is greater than 64.
- R9: A write offered while byte_count equals DEPTH is dropped and sets overflow. overflow stays 1 until reset or flush.
- R10: A control write (ctl_wr) with ctl_wdata bit 4 set empties the buffer and clears overflow. A write or read in the same cycle is ignored. A control write with bit 4 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Receiver offers a byte |
| wr_byte | input | 8 | Received byte |
| wr_tail | input | 1 | Byte is the last of its packet |
| rd_en | input | 1 | Firmware read of the data word; pops the valid bytes |
| rd_data | output | 32 | Current data word, little-endian |
| rd_lanes | output | 4 | Valid-byte code of rd_data |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data; bit 4 requests a flush |
| byte_count | output | 8 | Bytes held (width from DEPTH) |
| pending | output | 1 | Unread data present |
| end_of_data | output | 1 | Current chunk is the last |
| count_err | output | 1 | Count exceeds the chunk size |
| overflow | output | 1 | Sticky: a byte was dropped while full |

## Verification
On every cycle, the assertions check the lane code's shape, that end_of_data implies pending, and that the count stays bounded. They also check that an empty read leaves the count alone and returns zero, that a flush empties the buffer, and that overflow is set and held. Other behaviours are shown only by the bench scenarios, which compare against a byte-queue model. These are the byte order within a word, the cut of a word at a packet tail, and the exact count after a combined write and read. They also include the 64-byte threshold of end_of_data and count_err, and the fact that a control write without bit 4 does nothing.

// File: rtl/usb_out_fifo_rd.sv
module usb_out_fifo_rd #(
  parameter int DEPTH     = 128,
  parameter int CHUNK     = 64,
  parameter int FLUSH_BIT = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_valid,
  input  logic [7:0]                       wr_byte,
  input  logic                             wr_tail,
  input  logic                             rd_en,
  output logic [31:0]                      rd_data,
  output logic [3:0]                       rd_lanes,
  input  logic                             ctl_wr,
  input  logic [7:0]                       ctl_wdata,
  output logic [$clog2(DEPTH+1)-1:0]       byte_count,
  output logic                             pending,
  output logic                             end_of_data,
  output logic                             count_err,
  output logic                             overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] tail_mark;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic [2:0]       nvalid;
  logic             tail_seen;

  wire flush = ctl_wr & ctl_wdata[FLUSH_BIT];
  wire full  = (cnt == CW'(DEPTH));
  wire push  = wr_valid & ~full & ~flush;
  wire [2:0] pop_n = (rd_en & ~flush) ? nvalid : 3'd0;

  always_comb begin
    logic stop;
    stop    = 1'b0;
    nvalid  = 3'd0;
    rd_data = '0;
    for (int k = 0; k < 4; k++) begin
      if (!stop && CW'(k) < cnt) begin
        rd_data[8*k +: 8] = mem[rd_ptr + AW'(k)];
        nvalid = nvalid + 3'd1;
        if (tail_mark[rd_ptr + AW'(k)]) stop = 1'b1;
      end
    end
  end

  assign rd_lanes = 4'((5'd1 << nvalid) - 5'd1);

  always_comb begin
    tail_seen = 1'b0;
    for (int i = 0; i < CHUNK; i++)
      if (CW'(i) < cnt && tail_mark[rd_ptr + AW'(i)]) tail_seen = 1'b1;
  end

  assign byte_count  = cnt;
  assign pending     = (cnt != '0);
  assign end_of_data = pending & ((cnt < CW'(CHUNK)) | tail_seen);
  assign count_err   = (cnt > CW'(CHUNK));

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr]       <= wr_byte;
      tail_mark[wr_ptr] <= wr_tail;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else if (flush) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      rd_ptr <= rd_ptr + AW'(pop_n);
      cnt    <= cnt + CW'(push) - CW'(pop_n);
      if (wr_valid && full) overflow <= 1'b1;
    end
  end
endmodule

module usb_out_fifo_rd_chk #(
  parameter int DEPTH     = 128,
  parameter int FLUSH_BIT = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_valid,
  input logic                       rd_en,
  input logic                       ctl_wr,
  input logic [7:0]                 ctl_wdata,
  input logic [31:0]                rd_data,
  input logic [3:0]                 rd_lanes,
  input logic [$clog2(DEPTH+1)-1:0] byte_count,
  input logic                       pending,
  input logic                       end_of_data,
  input logic                       overflow
);
  localparam int CW = $clog2(DEPTH+1);
  wire flush_req = ctl_wr & ctl_wdata[FLUSH_BIT];

  // R4
  lane_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_lanes & (rd_lanes + 4'd1)) == 4'd0));
  // R7
  eod_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_of_data |-> pending);
  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_count <= CW'(DEPTH));
  // R5
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && byte_count == '0) |-> (rd_data == '0 && rd_lanes == '0));
  // R5
  empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && byte_count == '0 && !wr_valid && !flush_req) |=> byte_count == '0);
  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (byte_count == '0 && !overflow));
  // R9
  overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && byte_count == CW'(DEPTH) && !flush_req) |=> overflow);
  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !flush_req) |=> overflow);
endmodule

bind usb_out_fifo_rd usb_out_fifo_rd_chk #(.DEPTH(DEPTH), .FLUSH_BIT(FLUSH_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_en(rd_en),
  .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .rd_data(rd_data), .rd_lanes(rd_lanes),
  .byte_count(byte_count), .pending(pending), .end_of_data(end_of_data),
  .overflow(overflow)
);

// File: tb/usb_out_fifo_rd_tb.sv
module usb_out_fifo_rd_tb;
  localparam int DEPTH = 128;
  localparam int CHUNK = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_tail = 1'b0, rd_en = 1'b0, ctl_wr = 1'b0;
  logic [7:0] wr_byte = '0, ctl_wdata = '0;
  logic [31:0] rd_data;
  logic [3:0] rd_lanes;
  logic [7:0] byte_count;
  logic pending, end_of_data, count_err, overflow;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [8:0] q[$];
  bit m_ovf = 1'b0;

  always #2.5 clk = ~clk;

  usb_out_fifo_rd u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_tail(wr_tail),
    .rd_en(rd_en), .rd_data(rd_data), .rd_lanes(rd_lanes), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .byte_count(byte_count), .pending(pending),
    .end_of_data(end_of_data), .count_err(count_err), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_n();
    int n = 0;
    for (int k = 0; k < 4 && k < q.size(); k++) begin
      n++;
      if (q[k][8]) break;
    end
    return n;
  endfunction

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    for (int k = 0; k < exp_n(); k++) w[8*k +: 8] = q[k][7:0];
    return w;
  endfunction

  function automatic bit exp_eod();
    if (q.size() == 0) return 1'b0;
    if (q.size() < CHUNK) return 1'b1;
    for (int i = 0; i < CHUNK; i++) if (q[i][8]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check_all();
    logic [3:0] el = 4'((5'd1 << exp_n()) - 5'd1);
    chk(rd_data == exp_word(), "R3 rd_data", rd_data, exp_word());
    chk(rd_lanes == el, "R4 rd_lanes", 32'(rd_lanes), 32'(el));
    chk(byte_count == 8'(q.size()), "R2 byte_count", 32'(byte_count), q.size());
    chk(pending == (q.size() != 0), "R6 pending", 32'(pending), 32'(q.size() != 0));
    chk(end_of_data == exp_eod(), "R7 end_of_data", 32'(end_of_data), 32'(exp_eod()));
    chk(count_err == (q.size() > CHUNK), "R8 count_err", 32'(count_err), 32'(q.size() > CHUNK));
    chk(overflow == m_ovf, "R9 overflow", 32'(overflow), 32'(m_ovf));
  endtask

  task automatic cyc(input bit wv, input logic [7:0] wd, input bit wt, input bit re,
                     input bit cw, input logic [7:0] cd);
    int n;
    wr_valid = wv; wr_byte = wd; wr_tail = wt; rd_en = re; ctl_wr = cw; ctl_wdata = cd;
    #1;
    check_all();
    if (re && q.size() == 0)
      chk(rd_data == 0 && rd_lanes == 0, "R5 empty read", rd_data, 0);
    if (cw && cd[4]) begin
      q.delete();
      m_ovf = 1'b0;
    end else begin
      bit was_full = (q.size() == DEPTH);
      n = re ? exp_n() : 0;
      repeat (n) void'(q.pop_front());
      if (wv && was_full) m_ovf = 1'b1;
      else if (wv) q.push_back({wt, wd});
    end
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0; rd_en = 0; ctl_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(byte_count == 0 && !pending && !end_of_data && !count_err && !overflow,
        "R1 reset flags", {byte_count, pending, end_of_data, count_err, overflow}, 0);
    chk(rd_data == 0 && rd_lanes == 0, "R1 reset data", rd_data, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 empty read
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);

    // R3 R4: 6-byte packet then 3-byte packet
    for (int i = 0; i < 6; i++) cyc(1, 8'h10 + 8'(i), i == 5, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(1, 8'hA0 + 8'(i), i == 2, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 0, 0);

    // R7 R8: 70 bytes, no tail, then drain below 64
    for (int i = 0; i < 70; i++) cyc(1, 8'(i * 3), 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, 0);
    cyc(1, 8'h55, 1, 1, 0, 0);

    // R10 control write without bit 4 has no effect
    cyc(0, 0, 0, 0, 1, 8'hEF);
    cyc(0, 0, 0, 0, 0, 0);

    // R9: fill to full, then extra writes
    while (q.size() < DEPTH) cyc(1, 8'($urandom), 0, 0, 0, 0);
    cyc(1, 8'hEE, 0, 0, 0, 0);
    cyc(1, 8'hEF, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);

    // R10 flush with simultaneous write and read
    cyc(1, 8'h77, 0, 1, 1, 8'h10);
    cyc(0, 0, 0, 1, 0, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 1000);
      cyc($urandom % 2 == 0, 8'($urandom), $urandom % 16 == 0,
          $urandom % 5 < 2, r < 6, (r < 3) ? 8'h10 : 8'(($urandom) & 8'hEF));
    end
    for (int i = 0; i < 60; i++) cyc(0, 0, 0, 1, 0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule